// File: doc/BRIEF.md
# Keyed Windowed Watchdog with Clock Monitor

This block guards a processor against runaway code and a stopped oscillator. A counter advances on each idle-timer tick and must be restarted by a software write to an 8-bit service register before it reaches the selected limit. Each write carries a window choice, a monitor enable and a fixed key. The first write after reset fixes the window and the monitor enable. From then on each write must repeat the stored fields and the key exactly. A write that is wrong, too late, or too soon after a low-power exit produces a one-clock error pulse, and the count starts again from zero.

While the halt or idle input is high, the watchdog stops counting and ignores writes. The clock monitor keeps running in those modes. It reports when a sampled clock-present input stays low too long. When a low-power mode ends, the count restarts and a short lower window opens. Inside that window a service counts as an error.

Top module: `keyed_wdt`

## Requirements
- R1: While reset is low and right after it is released, wd_err and cm_err are low and rd_data reads 8'hE0 (window code 11 in bits [7:6], monitor enabled in bit 5, zeros in bits [4:0]).
- R2: The first write after reset is accepted, with no error, at any count below the widest limit W3, provided bits [4:0] equal 5'b01100. It stores the window code from bits [7:6] (00=W0, 01=W1, 10=W2, 11=W3 ticks) and the monitor enable from bit 5. rd_data then returns these fields, with bits [4:0] always zero.
- R3: After the first accepted write, a write whose 8 bits differ from the stored window, the stored enable and the key raises wd_err. The stored settings stay unchanged.
- R4: A write with a wrong key, the first write included, raises wd_err for exactly one clock. A rejected first write does not lock the settings.
- R5: If no service arrives, wd_err rises at the tick that brings the count of ticks since the last restart to the selected limit. Counting then restarts from zero.
- R6: In normal running, a correct write at any count below the limit raises no error and restarts the count.
- R7: While halt_mode or idle_mode is high, ticks are not counted, writes are ignored and wd_err stays low.
- R8: When both low-power inputs go low after either was high, the count restarts and a lower window of LOWER ticks opens. A write at a count below LOWER raises wd_err. A correct write at a count of LOWER or more is accepted.
- R9: With the monitor enabled, cm_err pulses for one clock once clk_present has been low for more than CM_LIMIT consecutive clocks. This applies whether or not a low-power mode is active.
- R10: With the monitor disabled, cm_err never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Idle-timer clock enable, one pulse per counted tick |
| wr_en | input | 1 | Service register write strobe |
| wr_data | input | 8 | Service write: window [7:6], monitor enable [5], key [4:0] |
| rd_data | output | 8 | Service register readback with the key field masked to zero |
| halt_mode | input | 1 | Halt low-power mode active |
| idle_mode | input | 1 | Idle low-power mode active |
| clk_present | input | 1 | Sampled oscillator-present indication |
| wd_err | output | 1 | One-clock watchdog error pulse |
| cm_err | output | 1 | One-clock clock-monitor error pulse |

## Verification
Service writes are driven with a wrong key, with a correct key but a changed window or enable bit, and with an exact match. Together these separate key checking from field locking. Each write is placed at different counts: one tick below the limit, exactly at the limit, and just below and at the lower-window bound after both a halt exit and an idle exit. This shows whether the upper and lower edges are off by one. The clock-present input is held low for runs one clock short of the threshold and one clock long enough, both in run mode and in halt, and again with the monitor disabled.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int W0       = 2048,
  parameter int W1       = 4096,
  parameter int W2       = 8192,
  parameter int W3       = 65536,
  parameter int LOWER    = 2048,
  parameter int CM_LIMIT = 64,
  parameter logic [4:0] KEY = 5'b01100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       halt_mode,
  input  logic       idle_mode,
  input  logic       clk_present,
  output logic       wd_err,
  output logic       cm_err
);
  localparam int CW = $clog2(W3 + 1);
  localparam int MW = $clog2(CM_LIMIT + 2);

  logic [CW-1:0] cnt, up_m1;
  logic [MW-1:0] cm_cnt;
  logic [1:0]    win_sel;
  logic          cm_en, locked, low_win, lp_q;

  wire lp       = halt_mode | idle_mode;
  wire lp_exit  = lp_q & ~lp;
  wire svc      = wr_en & ~lp;
  wire key_ok   = wr_data[4:0] == KEY;
  wire match_ok = locked ? (wr_data == {win_sel, cm_en, KEY}) : key_ok;
  wire early    = low_win && (cnt < CW'(LOWER));

  assign rd_data = {win_sel, cm_en, 5'b00000};

  always_comb begin
    case (win_sel)
      2'b00:   up_m1 = CW'(W0 - 1);
      2'b01:   up_m1 = CW'(W1 - 1);
      2'b10:   up_m1 = CW'(W2 - 1);
      default: up_m1 = CW'(W3 - 1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      win_sel <= 2'b11;
      cm_en   <= 1'b1;
      locked  <= 1'b0;
      low_win <= 1'b0;
      lp_q    <= 1'b0;
      wd_err  <= 1'b0;
    end else begin
      lp_q   <= lp;
      wd_err <= 1'b0;
      if (lp_exit) begin
        cnt     <= '0;
        low_win <= 1'b1;
      end else if (svc) begin
        cnt     <= '0;
        low_win <= 1'b0;
        if (match_ok && !early) begin
          if (!locked) begin
            win_sel <= wr_data[7:6];
            cm_en   <= wr_data[5];
            locked  <= 1'b1;
          end
        end else begin
          wd_err <= 1'b1;
        end
      end else if (tick && !lp) begin
        if (cnt >= up_m1) begin
          wd_err  <= 1'b1;
          cnt     <= '0;
          low_win <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cm_cnt <= '0;
      cm_err <= 1'b0;
    end else begin
      cm_err <= cm_en && !clk_present && (cm_cnt == MW'(CM_LIMIT));
      if (!cm_en || clk_present)
        cm_cnt <= '0;
      else if (cm_cnt != MW'(CM_LIMIT + 1))
        cm_cnt <= cm_cnt + MW'(1);
    end
  end

  AST_BAD_KEY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lp && !lp_q && wr_data[4:0] != KEY) |=> wd_err); // R4
  AST_LOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(win_sel) && $stable(cm_en))); // R3
  AST_LOWPWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lp |=> !wd_err); // R7
  AST_CM_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cm_en |=> !cm_err); // R10
  AST_CM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cm_err |=> !cm_err); // R9
  AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= up_m1); // R5
endmodule

// File: tb/keyed_wdt_test.sv
module keyed_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int W0 = 16, W1 = 32, W2 = 64, W3 = 128, LOWER = 8, CML = 5;

  logic clk = 1'b0;
  logic rst_n, tick, wr_en, halt_mode, idle_mode, clk_present;
  logic [7:0] wr_data, rd_data;
  logic wd_err, cm_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_wdt #(.W0(W0), .W1(W1), .W2(W2), .W3(W3), .LOWER(LOWER), .CM_LIMIT(CML)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .halt_mode(halt_mode), .idle_mode(idle_mode),
    .clk_present(clk_present), .wd_err(wd_err), .cm_err(cm_err));

  typedef struct {
    logic       wd;
    logic       cm;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int compared = 0, mismatched = 0;
  logic [7:0] exp_rd;

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      compared++;
      if (wd_err !== e.wd || cm_err !== e.cm || rd_data !== e.rd) begin
        mismatched++;
        $display("FAIL %s: actual wd=%b cm=%b rd=%h expected wd=%b cm=%b rd=%h",
                 e.tag, wd_err, cm_err, rd_data, e.wd, e.cm, e.rd);
      end
    end
  end

  task automatic step(input logic w, input logic [7:0] d, input logic t, input logic h,
                      input logic i, input logic cp, input logic ew, input logic ec,
                      input string tag);
    @(negedge clk);
    wr_en = w; wr_data = d; tick = t; halt_mode = h; idle_mode = i; clk_present = cp;
    q.push_back('{wd: ew, cm: ec, rd: exp_rd, tag: tag});
  endtask

  task automatic run(input int n, input logic t, input logic h, input logic i,
                     input logic cp, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 8'h00, t, h, i, cp, 1'b0, 1'b0, tag);
  endtask

  task automatic service(input logic [7:0] d, input logic ew, input string tag);
    step(1'b1, d, 1'b1, 1'b0, 1'b0, 1'b1, ew, 1'b0, tag);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (6000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung run expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
    halt_mode = 1'b0; idle_mode = 1'b0; clk_present = 1'b1;
    exp_rd = 8'hE0;
    repeat (3) @(negedge clk);
    compared++;
    if (wd_err !== 1'b0 || cm_err !== 1'b0 || rd_data !== 8'hE0) begin
      mismatched++;
      $display("FAIL R1 in reset: actual wd=%b cm=%b rd=%h expected wd=0 cm=0 rd=e0",
               wd_err, cm_err, rd_data);
    end
    rst_n = 1'b1;
    run(1, 0, 0, 0, 1, "R1 after release");

    // R9: monitor enabled by default, threshold at CML+1 low clocks
    run(5, 0, 0, 0, 0, "R9 short low run");
    run(1, 0, 0, 0, 1, "R9 recover");
    run(5, 0, 1, 0, 0, "R9 low in halt");
    step(0, 8'h00, 0, 1, 0, 0, 0, 1, "R9 pulse on sixth low");
    step(0, 8'h00, 0, 1, 0, 0, 0, 0, "R9 single pulse");
    run(1, 0, 1, 0, 1, "R9 halt clock back");
    step(0, 8'h00, 0, 0, 0, 1, 0, 0, "R8 halt exit before lock");
    run(10, 1, 0, 0, 1, "R8 past lower window");

    // R4: wrong key on first write, no lock
    service(8'hED, 1, "R4 wrong key first write");
    run(1, 1, 0, 0, 1, "R4 error is one clock");

    // R2: first service locks window 01 (W1) and monitor off
    run(100, 1, 0, 0, 1, "R2 wide window after reset");
    exp_rd = 8'h40;
    service(8'h4C, 0, "R2 first service");

    run(10, 1, 0, 0, 0, "R10 monitor disabled");

    // R6
    run(21, 1, 0, 0, 1, "R6 count to 31");
    service(8'h4C, 0, "R6 service one below limit");
    run(3, 1, 0, 0, 1, "R6 short wait");
    service(8'h4C, 0, "R6 service early in running");

    // R3
    service(8'hCC, 1, "R3 window change rejected");
    service(8'h6C, 1, "R3 monitor change rejected");

    // R5
    run(31, 1, 0, 0, 1, "R5 below limit");
    step(0, 8'h00, 1, 0, 0, 1, 1, 0, "R5 expiry at limit");
    run(31, 1, 0, 0, 1, "R5 restarted count");
    step(0, 8'h00, 1, 0, 0, 1, 1, 0, "R5 second expiry");

    // R7
    run(40, 1, 1, 0, 1, "R7 halt ticks ignored");
    step(1, 8'hFF, 1, 1, 0, 1, 0, 0, "R7 write in halt ignored");
    run(10, 1, 0, 1, 1, "R7 idle ticks ignored");

    // R8
    step(0, 8'h00, 1, 0, 0, 1, 0, 0, "R8 idle exit");
    run(7, 1, 0, 0, 1, "R8 inside lower window");
    service(8'h4C, 1, "R8 service too early");
    run(5, 1, 1, 0, 1, "R8 halt again");
    step(0, 8'h00, 1, 0, 0, 1, 0, 0, "R8 halt exit");
    run(8, 1, 0, 0, 1, "R8 reach lower bound");
    service(8'h4C, 0, "R8 service at lower bound");
    run(31, 1, 0, 0, 1, "R6 upper window after lower");
    service(8'h4C, 0, "R6 service after lower window");

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule